// File: doc/BRIEF.md
# Operating-System Tick Timer Channel

This block is one timer channel meant to give an operating system either a monotonic timestamp or a periodic or one-off tick interrupt. Software reaches it over a simple byte-addressed register bus made of four signals: valid, write, address and data. The channel has a compare value, a live counter and a mode bit. It also has two separate one-shot trigger registers, one to start and one to stop. A read-only flag reports whether the counter is actually running. The counter advances only on cycles where `tick_en` is high, so any prescaler outside the block sets the time base.

In interval mode the counter is loaded from the compare value when the channel starts. It then counts down. When it passes zero it reloads and emits a one-cycle interrupt, so a compare value of N−1 gives an interrupt every N ticks. In free-running mode the counter starts from zero and counts up, wrapping through its full range. It emits a one-cycle interrupt on the tick that brings it equal to the compare value, and it keeps counting afterwards. The usual sequence is: stop the channel, poll the flag until it clears, program the compare value and the mode, then start.

Top module: `ostimer_chan`

## Requirements
- R1: After reset the channel is stopped, the compare, control and counter registers read 0, and `irq` is low.
- R2: A write of a value with bit 0 set to the start trigger at offset 0x14 sets the running flag. The flag is bit 0 of offset 0x10 and reads 1 from the next clock. A start while already running reinitialises the counter. A start write with bit 0 clear has no effect.
- R3: A write of a value with bit 0 set to the stop trigger at offset 0x18 clears the running flag from the next clock. While stopped, the counter at offset 0x04 holds its value regardless of `tick_en`.
- R4: Interval mode is selected by control bit 1 = 0 at offset 0x20. In this mode a start loads the counter with the compare value at offset 0x00. The counter then decrements by one on each cycle with `tick_en` high and does not change on other cycles.
- R5: In interval mode, a tick taken at counter value 0 reloads the compare value and raises `irq` for exactly the following cycle. A compare value of C therefore gives one interrupt every C+1 ticks.
- R6: Free-running mode is selected by control bit 1 = 1. In this mode a start clears the counter to 0. The counter then increments by one per tick and wraps from all ones to 0 (CNT_W bits).
- R7: In free-running mode, the tick that makes the counter equal to the compare value raises `irq` for the following cycle, and counting continues. With a compare value of 0 this happens on the wrap.
- R8: Writes to the control register while running are ignored. Control reads back bit 1 only, with all other bits 0.
- R9: Reads of the start and stop triggers and of unmapped offsets return 0. The compare register keeps its low CNT_W bits, and its upper bits read 0.
- R10: `irq` is high only in the cycle after a tick taken while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count enable, one count per high cycle |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, same cycle (or one cycle later when REG_RDATA=1) |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A corrupted counter shows at the next read of offset 0x04, and it also moves the interrupt by a whole period or suppresses it. The bench therefore compares both the counter value and the number of interrupt cycles after each burst of ticks. A wrong running flag shows one cycle after a trigger write, either as a frozen counter or as one that keeps moving. A stuck-high interrupt is visible in the next cycle, because the bench counts every high cycle of `irq`.

// File: rtl/ostimer_pkg.sv
package ostimer_pkg;
   localparam logic [7:0] OFS_CMP   = 8'h00;
   localparam logic [7:0] OFS_CNT   = 8'h04;
   localparam logic [7:0] OFS_STAT  = 8'h10;
   localparam logic [7:0] OFS_START = 8'h14;
   localparam logic [7:0] OFS_STOP  = 8'h18;
   localparam logic [7:0] OFS_CTL   = 8'h20;

   localparam int MODE_BIT = 1;

   typedef enum logic {
      MODE_INTERVAL = 1'b0,
      MODE_FREERUN  = 1'b1
   } tmr_mode_e;
endpackage

// File: rtl/ostimer_regs.sv
module ostimer_regs
   import ostimer_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 32,
   parameter bit REG_RDATA = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              run,
   input  logic [CNT_W-1:0]  cnt,
   output logic [CNT_W-1:0]  cmp_q,
   output tmr_mode_e         mode_q,
   output logic              start_p,
   output logic              stop_p
);
   logic wr_en, rd_en;
   logic hit_cmp, hit_cnt, hit_stat, hit_start, hit_stop, hit_ctl;
   logic [DATA_W-1:0] rd_mux;
   logic wdata_unused;

   assign wr_en = bus_valid &  bus_write;
   assign rd_en = bus_valid & ~bus_write;

   assign hit_cmp   = (bus_addr == ADDR_W'(OFS_CMP));
   assign hit_cnt   = (bus_addr == ADDR_W'(OFS_CNT));
   assign hit_stat  = (bus_addr == ADDR_W'(OFS_STAT));
   assign hit_start = (bus_addr == ADDR_W'(OFS_START));
   assign hit_stop  = (bus_addr == ADDR_W'(OFS_STOP));
   assign hit_ctl   = (bus_addr == ADDR_W'(OFS_CTL));

   assign start_p = wr_en & hit_start & bus_wdata[0];
   assign stop_p  = wr_en & hit_stop  & bus_wdata[0];
   assign wdata_unused = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q  <= '0;
         mode_q <= MODE_INTERVAL;
      end else begin
         if (wr_en && hit_cmp)
            cmp_q <= bus_wdata[CNT_W-1:0];
         if (wr_en && hit_ctl && !run)
            mode_q <= tmr_mode_e'(bus_wdata[MODE_BIT]);
      end
   end

   always_comb begin
      rd_mux = '0;
      if (rd_en) begin
         if (hit_cmp)  rd_mux = DATA_W'(cmp_q);
         if (hit_cnt)  rd_mux = DATA_W'(cnt);
         if (hit_stat) rd_mux = DATA_W'(run);
         if (hit_ctl)  rd_mux = DATA_W'({mode_q, 1'b0});
      end
   end

   generate
      if (REG_RDATA) begin : g_rd_reg
         logic [DATA_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata_q <= '0;
            else        rdata_q <= rd_mux;
         end
         assign bus_rdata = rdata_q;
      end else begin : g_rd_comb
         assign bus_rdata = rd_mux;
      end
   endgenerate
endmodule

// File: rtl/ostimer_core.sv
module ostimer_core
   import ostimer_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             start_p,
   input  logic             stop_p,
   input  tmr_mode_e        mode,
   input  logic [CNT_W-1:0] cmp,
   output logic             run,
   output logic [CNT_W-1:0] cnt,
   output logic             irq
);
   logic             step;
   logic [CNT_W-1:0] cnt_up, cnt_nx;
   logic             evt;

   assign step   = run & tick_en & ~start_p;
   assign cnt_up = cnt + CNT_W'(1);

   always_comb begin
      cnt_nx = cnt;
      evt    = 1'b0;
      if (mode == MODE_INTERVAL) begin
         if (cnt == '0) begin
            cnt_nx = cmp;
            evt    = 1'b1;
         end else begin
            cnt_nx = cnt - CNT_W'(1);
         end
      end else begin
         cnt_nx = cnt_up;
         evt    = (cnt_up == cmp);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         cnt <= '0;
         irq <= 1'b0;
      end else begin
         if (start_p)     run <= 1'b1;
         else if (stop_p) run <= 1'b0;

         if (start_p)
            cnt <= (mode == MODE_INTERVAL) ? cmp : '0;
         else if (step)
            cnt <= cnt_nx;

         irq <= step & evt;
      end
   end
endmodule

// File: rtl/ostimer_chan.sv
module ostimer_chan
   import ostimer_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 32,
   parameter bit REG_RDATA = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   generate
      if (CNT_W < 8 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("ostimer_chan: CNT_W must lie in 8..DATA_W");
      end
      if (ADDR_W < 6) begin : g_bad_addr_w
         $error("ostimer_chan: ADDR_W must reach offset 0x20");
      end
   endgenerate

   logic             run_w, start_w, stop_w;
   logic [CNT_W-1:0] cnt_w, cmp_w;
   tmr_mode_e        mode_w;

   ostimer_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .REG_RDATA(REG_RDATA)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .run(run_w), .cnt(cnt_w),
      .cmp_q(cmp_w), .mode_q(mode_w),
      .start_p(start_w), .stop_p(stop_w)
   );

   ostimer_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .start_p(start_w), .stop_p(stop_w),
      .mode(mode_w), .cmp(cmp_w),
      .run(run_w), .cnt(cnt_w), .irq(irq)
   );
endmodule

// File: rtl/ostimer_chan_chk.sv
module ostimer_chan_chk #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 32,
   parameter bit REG_RDATA = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq,
   input logic              run,
   input logic              start_p,
   input logic              stop_p,
   input logic              mode,
   input logic [CNT_W-1:0]  cnt
);
   p_start_sets_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_p |=> run);

   p_stop_clears_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_p && !start_p) |=> !run);

   p_frozen_when_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !start_p) |=> $stable(cnt));

   p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick_en && !start_p && !mode && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1));

   p_count_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick_en && !start_p && mode) |=> cnt == $past(cnt) + CNT_W'(1));

   p_ctl_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> $stable(mode));

   p_irq_after_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(run && tick_en));

   generate
      if (!REG_RDATA) begin : g_rd_chk
         p_trigger_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && !bus_write &&
             (bus_addr == ADDR_W'(8'h14) || bus_addr == ADDR_W'(8'h18))) |-> bus_rdata == '0);
      end
   endgenerate
endmodule

bind ostimer_chan ostimer_chan_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .REG_RDATA(REG_RDATA)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
   .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
   .bus_rdata(bus_rdata), .irq(irq),
   .run(run_w), .start_p(start_w), .stop_p(stop_w),
   .mode(mode_w), .cnt(cnt_w)
);

// File: tb/ostimer_chan_bench.sv
module ostimer_chan_bench;
   localparam int CNT_W  = 12;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 32;
   localparam int CMOD   = 1 << CNT_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick_en = 1'b0;
   logic              bus_valid = 1'b0;
   logic              bus_write = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic              irq;

   int errors = 0;
   int checks = 0;
   int irq_seen = 0;

   always #2.5 clk = ~clk;

   ostimer_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_ostimer_chan (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   always @(negedge clk) if (irq) irq_seen++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_valid = 1'b0;
   endtask

   task automatic ticks(input int k);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (k) @(negedge clk);
      tick_en = 1'b0;
      @(negedge clk);
   endtask

   function automatic logic [31:0] exp_cnt(input bit fr, input int c, input int k);
      if (fr) return 32'(k % CMOD);
      return 32'(c - (k % (c + 1)));
   endfunction

   function automatic int exp_irq(input bit fr, input int c, input int k);
      if (fr) return (k >= c) ? 1 : 0;
      return k / (c + 1);
   endfunction

   task automatic arm(input bit fr, input int c);
      wr(8'h18, 32'h1);
      wr(8'h20, fr ? 32'h2 : 32'h0);
      wr(8'h00, 32'(c));
      wr(8'h14, 32'h1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int base;
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(8'h10, v); chk("R1 status", v, 0);
      rd(8'h00, v); chk("R1 compare", v, 0);
      rd(8'h04, v); chk("R1 counter", v, 0);
      rd(8'h20, v); chk("R1 control", v, 0);
      chk("R1 irq", 32'(irq), 0);

      // R2 start with bit0 clear is ignored
      wr(8'h14, 32'hFE);
      rd(8'h10, v); chk("R2 start bit0 clear", v, 0);

      // R9 compare width and read-zero registers
      wr(8'h00, 32'hFFFF_F123);
      rd(8'h00, v); chk("R9 compare width", v, 32'h123);
      rd(8'h14, v); chk("R9 start reads 0", v, 0);
      rd(8'h18, v); chk("R9 stop reads 0", v, 0);
      rd(8'h08, v); chk("R9 unmapped reads 0", v, 0);

      // R4 R5 interval, period 5
      arm(1'b0, 4);
      rd(8'h10, v); chk("R2 running flag", v, 1);
      rd(8'h04, v); chk("R4 load on start", v, 4);
      base = irq_seen;
      ticks(3);
      rd(8'h04, v); chk("R4 count down", v, 1);
      ticks(9);
      rd(8'h04, v); chk("R5 reload position", v, 2);
      chk("R5 irq count", 32'(irq_seen - base), 2);

      // R8 control write while running ignored
      wr(8'h20, 32'h2);
      rd(8'h20, v); chk("R8 ctl locked", v, 0);

      // R3 stop freezes counter, R10 no irq when stopped
      wr(8'h18, 32'h1);
      rd(8'h10, v); chk("R3 flag cleared", v, 0);
      base = irq_seen;
      ticks(20);
      rd(8'h04, v); chk("R3 frozen", v, 2);
      chk("R10 no irq stopped", 32'(irq_seen - base), 0);

      wr(8'h20, 32'hFF);
      rd(8'h20, v); chk("R8 ctl readback", v, 2);

      // R6 R7 free-run, compare 0 fires on wrap
      arm(1'b1, 0);
      rd(8'h04, v); chk("R6 clear on start", v, 0);
      base = irq_seen;
      ticks(CMOD - 1);
      rd(8'h04, v); chk("R6 near wrap", v, 32'(CMOD - 1));
      chk("R7 no irq before wrap", 32'(irq_seen - base), 0);
      ticks(1);
      rd(8'h04, v); chk("R6 wrapped", v, 0);
      chk("R7 irq on wrap", 32'(irq_seen - base), 1);

      // R2 restart while running
      arm(1'b1, 100);
      ticks(50);
      wr(8'h14, 32'h1);
      rd(8'h04, v); chk("R2 restart", v, 0);

      // random mix
      for (int i = 0; i < 10; i++) begin
         bit fr;
         int c, k;
         fr = 1'($urandom % 2);
         c  = 15 + int'($urandom % 186);
         k  = 1 + int'($urandom % 600);
         arm(fr, c);
         base = irq_seen;
         ticks(k);
         rd(8'h04, v);
         chk(fr ? "R6 random count" : "R4 random count", v, exp_cnt(fr, c, k));
         chk(fr ? "R7 random irq" : "R5 random irq", 32'(irq_seen - base), 32'(exp_irq(fr, c, k)));
      end

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule